// File: doc/BRIEF.md
# Banked Scratchpad Read Conflict Serializer

This block stands in front of an on-chip scratchpad split into 32 banks, with 4-byte words spread across the banks in rotation. It accepts one read request for a whole group of lanes at once. The request carries an active-lane mask and one byte address per lane. The block then splits the active lanes into rounds that are free of conflicts. In each round it reads at most one word from each bank. All lanes that want that word receive it together in the same round.

When every active lane has been served, the block raises a one-cycle completion pulse. At the same time it reports the conflict degree, which is the number of rounds that were needed. That count equals the largest number of distinct words requested from any single bank. The storage behind the banks is a simple array. A plain write port fills it with one word per cycle.

Top module: `bank_conflict_serializer`

## Requirements
- R1: After reset, `busy` is 0, `rsp_valid` is 0 and `rsp_degree` is 0.
- R2: Lane byte address A selects bank A[6:2], so addresses 128 bytes apart share a bank. Two lanes name the same word when A[31:2] is equal. The storage holds 256 words, indexed by A[9:2], and higher address bits wrap. The byte offset A[1:0] is ignored.
- R3: `rsp_degree` equals the maximum, over all banks, of the number of distinct words requested from that bank by active lanes.
- R4: Lanes that request the same word are served in the same round. When every lane reads one address, the degree is 1.
- R5: For lane addresses of lane×stride words with all 32 lanes active: an odd stride gives degree 1, a stride of 2 words gives degree 2, and a stride of 32 words gives degree 32.
- R6: Once the request completes, each active lane's slice of `rsp_data` holds the stored word at its address, and each inactive lane's slice is 0.
- R7: A request is accepted on a rising edge where `req_valid` is 1 and `busy` is 0. `busy` stays 1 until `rsp_valid` pulses for exactly one cycle. That pulse comes on the (degree+1)-th rising edge after the accepting edge.
- R8: An empty mask completes with degree 0, and `rsp_valid` pulses on the first rising edge after acceptance.
- R9: A `req_valid` while `busy` is 1 is ignored. The running request's degree and data are unchanged.
- R10: A rising edge with `wr_en` at 1 stores `wr_data` at word index `wr_word`, and later reads return that value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Storage write strobe |
| wr_word | input | 8 | Word index to write |
| wr_data | input | 32 | Word to store |
| req_valid | input | 1 | Read request strobe |
| req_mask | input | 32 | Active lanes, bit L for lane L |
| req_addr | input | 1024 | Byte addresses, lane L at bits [32L+31:32L] |
| busy | output | 1 | Request in progress |
| rsp_valid | output | 1 | One-cycle completion pulse |
| rsp_degree | output | 6 | Number of rounds taken (0 to 32) |
| rsp_data | output | 1024 | Returned words, lane L at bits [32L+31:32L] |

## Verification
The hardest state to reach is a bank holding a mixture: several distinct words, some of them shared by more than one lane, while other banks see a single word or nothing at all. The stimulus reaches this state with a patterned partial mask and with addresses that repeat words inside a bank. The expected degree for these cases is computed by a separate count of distinct words per bank. A second hard case is an intruding request that lands in the middle of a 32-round serialization. The bench drives that request a few cycles into the stride-32 pattern, with a different mask and different addresses, and then checks that the original results are untouched.

// File: rtl/bank_conflict_serializer.sv
module bank_conflict_serializer #(
  parameter int LANES = 32,
  parameter int BANKS = 32,
  parameter int ROWS  = 8,
  parameter int AW    = 32,
  parameter int DW    = 32,
  localparam int BW   = $clog2(BANKS),
  localparam int IDXW = $clog2(BANKS * ROWS),
  localparam int CW   = $clog2(LANES + 1)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_en,
  input  logic [IDXW-1:0]     wr_word,
  input  logic [DW-1:0]       wr_data,
  input  logic                req_valid,
  input  logic [LANES-1:0]    req_mask,
  input  logic [LANES*AW-1:0] req_addr,
  output logic                busy,
  output logic                rsp_valid,
  output logic [CW-1:0]       rsp_degree,
  output logic [LANES*DW-1:0] rsp_data
);

  logic [DW-1:0]    mem [BANKS*ROWS];
  logic [AW-3:0]    waddr [LANES];
  logic [LANES-1:0] pend;
  logic [LANES-1:0] served;
  logic [CW-1:0]    rounds;
  logic             unused_offset;

  always_comb begin
    unused_offset = 1'b0;
    for (int l = 0; l < LANES; l++)
      unused_offset = unused_offset ^ (^req_addr[l*AW +: 2]);
  end

  always_comb begin
    logic          found;
    logic [AW-3:0] pick;
    served = '0;
    for (int b = 0; b < BANKS; b++) begin
      found = 1'b0;
      pick  = '0;
      for (int l = 0; l < LANES; l++) begin
        if (!found && pend[l] && waddr[l][BW-1:0] == BW'(b)) begin
          found = 1'b1;
          pick  = waddr[l];
        end
      end
      for (int l = 0; l < LANES; l++) begin
        if (pend[l] && waddr[l][BW-1:0] == BW'(b) && waddr[l] == pick)
          served[l] = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_word] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (!busy && req_valid) begin
      for (int l = 0; l < LANES; l++)
        waddr[l] <= req_addr[l*AW+2 +: AW-2];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy       <= 1'b0;
      rsp_valid  <= 1'b0;
      rsp_degree <= '0;
      rsp_data   <= '0;
      pend       <= '0;
      rounds     <= '0;
    end else begin
      rsp_valid <= 1'b0;
      if (!busy) begin
        if (req_valid) begin
          busy     <= 1'b1;
          pend     <= req_mask;
          rounds   <= '0;
          rsp_data <= '0;
        end
      end else if (pend == '0) begin
        busy       <= 1'b0;
        rsp_valid  <= 1'b1;
        rsp_degree <= rounds;
      end else begin
        pend   <= pend & ~served;
        rounds <= rounds + 1'b1;
        for (int l = 0; l < LANES; l++) begin
          if (served[l])
            rsp_data[l*DW +: DW] <= mem[waddr[l][IDXW-1:0]];
        end
      end
    end
  end

endmodule

// File: rtl/serializer_checks.sv
module serializer_checks #(
  parameter int LANES = 32,
  localparam int CW   = $clog2(LANES + 1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          req_valid,
  input logic          busy,
  input logic          rsp_valid,
  input logic [CW-1:0] rsp_degree
);

  p_accept_r7: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && !busy |=> busy);

  p_busy_until_done_r9: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> busy || rsp_valid);

  p_single_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);

  p_done_ends_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> !busy && $past(busy));

  p_degree_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> rsp_degree <= CW'(LANES));

endmodule

bind bank_conflict_serializer serializer_checks #(.LANES(LANES)) u_chk (.*);

// File: tb/tb_bank_conflict_serializer.sv
module tb_bank_conflict_serializer;
  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          wr_en = 1'b0;
  logic [7:0]    wr_word = '0;
  logic [31:0]   wr_data = '0;
  logic          req_valid = 1'b0;
  logic [31:0]   req_mask = '0;
  logic [1023:0] req_addr = '0;
  logic          busy, rsp_valid;
  logic [5:0]    rsp_degree;
  logic [1023:0] rsp_data;

  logic [31:0] la [32];
  logic [31:0] mm [256];
  int n_chk = 0;
  int n_bad = 0;

  always #5 clk = ~clk;

  bank_conflict_serializer dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_word(wr_word), .wr_data(wr_data),
    .req_valid(req_valid), .req_mask(req_mask), .req_addr(req_addr),
    .busy(busy), .rsp_valid(rsp_valid), .rsp_degree(rsp_degree), .rsp_data(rsp_data));

  task automatic chk(input string req, input logic ok, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int model_degree(input logic [31:0] m);
    int worst = 0;
    for (int b = 0; b < 32; b++) begin
      int cnt = 0;
      for (int i = 0; i < 32; i++) begin
        logic dup = 1'b0;
        if (m[i] && la[i][6:2] == b[4:0]) begin
          for (int j = 0; j < i; j++)
            if (m[j] && la[j][31:2] == la[i][31:2]) dup = 1'b1;
          if (!dup) cnt++;
        end
      end
      if (cnt > worst) worst = cnt;
    end
    return worst;
  endfunction

  task automatic write_word(input int idx, input logic [31:0] val);
    @(negedge clk);
    wr_en = 1'b1; wr_word = idx[7:0]; wr_data = val;
    @(negedge clk);
    wr_en = 1'b0;
    mm[idx] = val;
  endtask

  task automatic run_case(input string tag, input logic [31:0] m, input int known, input int intrude_at);
    int exp;
    int n;
    exp = (known >= 0) ? known : model_degree(m);
    @(negedge clk);
    req_valid = 1'b1; req_mask = m;
    for (int l = 0; l < 32; l++) req_addr[l*32 +: 32] = la[l];
    @(negedge clk);
    req_valid = 1'b0;
    n = 1;
    chk({tag, " R7 busy after accept"}, busy === 1'b1, {31'd0, busy}, 32'd1);
    while (!rsp_valid && n < 200) begin
      if (n == intrude_at) begin
        req_valid = 1'b1; req_mask = ~m;
        for (int l = 0; l < 32; l++) req_addr[l*32 +: 32] = 32'h4;
      end
      @(negedge clk);
      req_valid = 1'b0;
      n++;
    end
    // done rises on edge degree+1 after the accepting edge; the first sample follows the accepting edge
    chk({tag, " R7 latency"}, n == exp + 2, n, exp + 2);
    chk({tag, " R3 degree"}, rsp_degree == 6'(exp), {26'd0, rsp_degree}, exp);
    for (int l = 0; l < 32; l++) begin
      logic [31:0] e;
      e = m[l] ? mm[la[l][9:2]] : 32'd0;
      chk({tag, " R6 lane data"}, rsp_data[l*32 +: 32] === e, rsp_data[l*32 +: 32], e);
    end
    @(negedge clk);
    chk({tag, " R7 single pulse"}, rsp_valid === 1'b0 && busy === 1'b0, {30'd0, rsp_valid, busy}, 32'd0);
  endtask

  task automatic t_reset;
    chk("R1 busy", busy === 1'b0, {31'd0, busy}, 0);
    chk("R1 rsp_valid", rsp_valid === 1'b0, {31'd0, rsp_valid}, 0);
    chk("R1 degree", rsp_degree === 6'd0, {26'd0, rsp_degree}, 0);
  endtask

  task automatic t_broadcast;
    for (int l = 0; l < 32; l++) la[l] = 32'h40;
    run_case("R4 broadcast", 32'hFFFF_FFFF, 1, -1);
  endtask

  task automatic t_strides;
    for (int l = 0; l < 32; l++) la[l] = l * 4;
    run_case("R5 stride1", 32'hFFFF_FFFF, 1, -1);
    for (int l = 0; l < 32; l++) la[l] = l * 12 + 1;
    run_case("R5 stride3 R2 offset", 32'hFFFF_FFFF, 1, -1);
    for (int l = 0; l < 32; l++) la[l] = l * 8;
    run_case("R5 stride2", 32'hFFFF_FFFF, 2, -1);
    for (int l = 0; l < 32; l++) la[l] = l * 128;
    run_case("R5 R2 stride32", 32'hFFFF_FFFF, 32, -1);
  endtask

  task automatic t_mixed;
    for (int l = 0; l < 32; l++) la[l] = ((l * 7) % 5) * 128 + (l % 3) * 4 + (l % 2) * 512;
    run_case("R3 mixed", 32'hA5A5_F00F, -1, -1);
    for (int l = 0; l < 32; l++) la[l] = (l < 8) ? (l % 2) * 128 : l * 4;
    run_case("R4 R3 shared words", 32'hFFFF_FFFF, 2, -1);
  endtask

  task automatic t_empty;
    for (int l = 0; l < 32; l++) la[l] = l * 128;
    run_case("R8 empty", 32'h0, 0, -1);
  endtask

  task automatic t_ignore;
    for (int l = 0; l < 32; l++) la[l] = l * 128 + 256;
    run_case("R9 intrude", 32'hFFFF_FFFF, 32, 3);
  endtask

  task automatic t_write;
    write_word(5, 32'hDEAD_BEEF);
    for (int l = 0; l < 32; l++) la[l] = 32'h14;
    run_case("R10 write", 32'h0000_FFFF, 1, -1);
    chk("R10 stored", rsp_data[31:0] === 32'hDEAD_BEEF, rsp_data[31:0], 32'hDEAD_BEEF);
  endtask

  initial begin
    #2_000_000;
    n_bad++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (2) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    for (int i = 0; i < 256; i++) write_word(i, (i * 32'h9E37_79B1) ^ 32'h5A5A_0000);
    t_broadcast();
    t_strides();
    t_mixed();
    t_empty();
    t_ignore();
    t_write();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule